// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read/Write Sequencer

This block sits between a simple request/ready bus and a single serial NOR flash device. A bus read or write of one to four bytes becomes one complete SPI transaction. The block pulls chip select low and sends an opcode taken from configuration. It then sends a 24-bit flash address, wrapped into the segment assigned to that chip select. Fast-read accesses add a run of 0xFF filler bytes. The data bytes follow last, and chip select then goes high again.

The transfer shape comes from a two-bit access-mode input. The opcode, filler count and SCLK divider are further configuration inputs, sampled when a request is accepted. When a request's direction does not match the mode, the block completes it at once and leaves the flash untouched. A bus master raises `req_i` with its operands and holds them until `ready_o` pulses.

Top module: `spiflash_seq_top`

## Requirements
- R1: Mode encoding is 0 = read, 1 = fast read, 2 = write, 3 = off. An accepted access drives `cs_no` low, and the first byte sent is `cfg_cmd_i`.
- R2: The three bytes after the opcode are the flash address, sent in this order: bits 23:16, then bits 15:8, then bits 7:0.
- R3: The address sent is `addr_i` taken modulo 2^SEG_AW. With the default SEG_AW = 20, bits 23:20 are sent as zero.
- R4: In fast-read mode, exactly `cfg_dummy_i` bytes of 0xFF follow the address.
- R5: In read and write modes, no filler bytes are sent, whatever value `cfg_dummy_i` holds.
- R6: A read of S bytes sends S bytes of 0x00. The first byte received lands in `rdata_o[7:0]` and byte i lands in `rdata_o[8i+7:8i]`. Bytes above S read as zero.
- R7: A write of S bytes sends `wdata_i[7:0]` first and then each higher byte in turn.
- R8: SPI runs in mode 0. SCLK idles low, bits go out MSB first, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. Each SCLK phase lasts max(`cfg_div_i`, 2) clock cycles.
- R9: Between accesses, `cs_no` stays high for at least one SCLK period of the access just ended. `ready_o` stays low while a transaction or this gap is in progress.
- R10: `ready_o` is a single-cycle pulse that comes with valid `rdata_o`, once per request.
- R11: The following requests complete with a `ready_o` pulse, `rdata_o` = 0 and no chip-select activity: a write in a read mode, a read in write mode, or any request in mode 3.
- R12: A size of 0 is treated as 1, and a size above 4 is treated as 4.
- R13: After reset, `cs_no` = 1, `sclk_o` = 0, `mosi_o` = 0 and `ready_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 2 | Access mode (R1 encoding) |
| cfg_cmd_i | input | 8 | Opcode byte |
| cfg_dummy_i | input | DUMMY_W | Filler byte count for fast read |
| cfg_div_i | input | DIV_W | System clocks per SCLK phase (min 2) |
| req_i | input | 1 | Access request, held until ready |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read data |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The assertions assume that the master holds `req_i` and its operands steady until `ready_o`, then drops `req_i`. They also assume that configuration does not change while chip select is low. The bench drives every request at a falling clock edge. It releases the request on the falling edge at which it sees `ready_o`, and changes configuration only between accesses. Its flash model follows SPI mode 0 exactly, so the check on MOSI timing is made against a well-behaved peer.

// File: rtl/spiflash_seq_pkg.sv
package spiflash_seq_pkg;
  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_FAST  = 2'd1,
    MD_WRITE = 2'd2,
    MD_OFF   = 2'd3
  } acc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_GAP
  } seq_state_e;

  localparam int unsigned HDR_BYTES = 4;  // opcode + 3 address bytes
endpackage

// File: rtl/spiflash_addr_wrap.sv
module spiflash_addr_wrap #(
  parameter int unsigned AW     = 24,
  parameter int unsigned SEG_AW = 20
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] SEG_MASK = AW'((64'd1 << SEG_AW) - 64'd1);

  assign addr_o = addr_i & SEG_MASK;
endmodule

// File: rtl/spiflash_byte_shifter.sv
module spiflash_byte_shifter #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       tx_i,
  input  logic [DIV_W-1:0] hd_i,
  input  logic             miso_i,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  logic             active_q;
  logic             sclk_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic             phase_end;

  assign phase_end = active_q && (cnt_q == hd_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      sh_q     <= '0;
      rx_q     <= '0;
      cnt_q    <= '0;
      bit_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
      sh_q     <= tx_i;
      cnt_q    <= '0;
      bit_q    <= '0;
    end else if (active_q) begin
      if (phase_end) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign done_o = phase_end && sclk_q && (bit_q == 3'd7);
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = active_q & sh_q[7];

  // R8: data line holds while the clock is high
  a_r8_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/spiflash_seq_ctrl.sv
module spiflash_seq_ctrl
  import spiflash_seq_pkg::*;
#(
  parameter int unsigned DUMMY_W = 3,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SZ_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cfg_mode_i,
  input  logic [7:0]         cfg_cmd_i,
  input  logic [DUMMY_W-1:0] cfg_dummy_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [23:0]        addr_i,
  input  logic [SZ_W-1:0]    size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               sh_done_i,
  input  logic [7:0]         sh_rx_i,
  output logic               sh_start_o,
  output logic [7:0]         sh_tx_o,
  output logic [DIV_W-1:0]   hd_o,
  output logic               cs_no,
  output logic               ready_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned MAX_BYTES = DATA_W / 8;
  localparam int unsigned MAX_TOT   = HDR_BYTES + (1 << DUMMY_W) - 1 + MAX_BYTES;
  localparam int unsigned IDX_W     = $clog2(MAX_TOT);
  localparam int unsigned JW        = $clog2(MAX_BYTES);

  seq_state_e           state_q;
  logic [IDX_W-1:0]     idx_q, last_q, nidx, dbase, jfull;
  logic [7:0]           cmd_q;
  logic [23:0]          addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic [DUMMY_W-1:0]   nd_q;
  logic                 rd_q;
  logic [DIV_W-1:0]     hd_q;
  logic [DIV_W:0]       gap_q;
  logic                 cs_n_q, ready_q;

  acc_mode_e            mode;
  logic                 acc_ok;
  logic [SZ_W-1:0]      sz_eff;
  logic [DUMMY_W-1:0]   nd_eff;
  logic [DIV_W-1:0]     hd_eff;

  assign mode   = acc_mode_e'(cfg_mode_i);
  assign acc_ok = ((mode == MD_READ || mode == MD_FAST) && !we_i) ||
                  (mode == MD_WRITE && we_i);
  assign nd_eff = (mode == MD_FAST) ? cfg_dummy_i : '0;
  assign hd_eff = (cfg_div_i < DIV_W'(2)) ? DIV_W'(2) : cfg_div_i;

  always_comb begin
    if (size_i == '0)                        sz_eff = SZ_W'(1);
    else if (size_i > SZ_W'(MAX_BYTES))      sz_eff = SZ_W'(MAX_BYTES);
    else                                     sz_eff = size_i;
  end

  assign nidx  = (state_q == ST_LEAD) ? '0 : idx_q + IDX_W'(1);
  assign dbase = IDX_W'(HDR_BYTES) + IDX_W'(nd_q);
  assign jfull = nidx - dbase;

  always_comb begin
    if (nidx == '0)                  sh_tx_o = cmd_q;
    else if (nidx == IDX_W'(1))      sh_tx_o = addr_q[23:16];
    else if (nidx == IDX_W'(2))      sh_tx_o = addr_q[15:8];
    else if (nidx == IDX_W'(3))      sh_tx_o = addr_q[7:0];
    else if (nidx < dbase)           sh_tx_o = 8'hFF;
    else if (rd_q)                   sh_tx_o = 8'h00;
    else                             sh_tx_o = wdata_q[8*jfull[JW-1:0] +: 8];
  end

  assign sh_start_o = (state_q == ST_LEAD) ||
                      (state_q == ST_XFER && sh_done_i && idx_q != last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      nd_q    <= '0;
      rd_q    <= 1'b0;
      hd_q    <= DIV_W'(2);
      gap_q   <= '0;
      cs_n_q  <= 1'b1;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          hd_q    <= hd_eff;
          rdata_q <= '0;
          if (acc_ok) begin
            cmd_q   <= cfg_cmd_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            nd_q    <= nd_eff;
            rd_q    <= !we_i;
            last_q  <= IDX_W'(HDR_BYTES - 1) + IDX_W'(nd_eff) + IDX_W'(sz_eff);
            cs_n_q  <= 1'b0;
            state_q <= ST_LEAD;
          end else begin
            ready_q <= 1'b1;
            gap_q   <= {hd_eff, 1'b0} - (DIV_W+1)'(1);
            state_q <= ST_GAP;
          end
        end
        ST_LEAD: begin
          idx_q   <= '0;
          state_q <= ST_XFER;
        end
        ST_XFER: if (sh_done_i) begin
          for (int b = 0; b < MAX_BYTES; b++) begin
            if (rd_q && idx_q >= dbase && (idx_q - dbase) == IDX_W'(b))
              rdata_q[8*b +: 8] <= sh_rx_i;
          end
          if (idx_q == last_q) begin
            cs_n_q  <= 1'b1;
            ready_q <= 1'b1;
            gap_q   <= {hd_q, 1'b0} - (DIV_W+1)'(1);
            state_q <= ST_GAP;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_GAP: begin
          if (gap_q == '0) state_q <= ST_IDLE;
          else             gap_q   <= gap_q - (DIV_W+1)'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hd_o    = hd_q;
  assign cs_no   = cs_n_q;
  assign ready_o = ready_q;
  assign rdata_o = rdata_q;

  // R10: completion is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
  // R9: completion only once the flash is deselected
  a_r9_ready_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> cs_n_q);
endmodule

// File: rtl/spiflash_seq_top.sv
module spiflash_seq_top
  import spiflash_seq_pkg::*;
#(
  parameter int unsigned SEG_AW  = 20,
  parameter int unsigned DUMMY_W = 3,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         cfg_mode_i,
  input  logic [7:0]         cfg_cmd_i,
  input  logic [DUMMY_W-1:0] cfg_dummy_i,
  input  logic [DIV_W-1:0]   cfg_div_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [23:0]        addr_i,
  input  logic [2:0]         size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               ready_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               sclk_o,
  output logic               cs_no,
  output logic               mosi_o,
  input  logic               miso_i
);
  logic [23:0]      addr_w;
  logic             sh_start, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic [DIV_W-1:0] hd;

  spiflash_addr_wrap #(.AW(24), .SEG_AW(SEG_AW)) u_wrap (
    .addr_i (addr_i),
    .addr_o (addr_w)
  );

  spiflash_seq_ctrl #(
    .DUMMY_W (DUMMY_W),
    .DIV_W   (DIV_W),
    .DATA_W  (DATA_W),
    .SZ_W    (3)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_mode_i  (cfg_mode_i),
    .cfg_cmd_i   (cfg_cmd_i),
    .cfg_dummy_i (cfg_dummy_i),
    .cfg_div_i   (cfg_div_i),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_w),
    .size_i      (size_i),
    .wdata_i     (wdata_i),
    .sh_done_i   (sh_done),
    .sh_rx_i     (sh_rx),
    .sh_start_o  (sh_start),
    .sh_tx_o     (sh_tx),
    .hd_o        (hd),
    .cs_no       (cs_no),
    .ready_o     (ready_o),
    .rdata_o     (rdata_o)
  );

  spiflash_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .hd_i    (hd),
    .miso_i  (miso_i),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
  );

  // Deselect time tracker for the gap check
  logic [3:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hi_cnt_q <= 4'hF;
    else if (!cs_no)                 hi_cnt_q <= '0;
    else if (hi_cnt_q != 4'hF)       hi_cnt_q <= hi_cnt_q + 4'd1;
  end

  // R8: no clock edges toward a deselected flash
  a_r8_sclk_idle_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R9: minimum deselect time, one period at the fastest divider
  a_r9_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt_q >= 4'd4));
endmodule

// File: tb/spiflash_seq_top_bench.sv
module spiflash_seq_top_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic        we;
    logic [23:0] addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [2:0]  dummy;
    logic [7:0]  cmd;
    logic [3:0]  div;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 24'h012345, 3'd4, 32'h0,        3'd5, 8'h03, 4'd2},
    '{2'd1, 1'b0, 24'h0ABCDE, 3'd2, 32'h0,        3'd1, 8'h0B, 4'd2},
    '{2'd2, 1'b1, 24'h0F0010, 3'd3, 32'hAABBCCDD, 3'd3, 8'h02, 4'd3},
    '{2'd1, 1'b0, 24'h7FFFFF, 3'd1, 32'h0,        3'd7, 8'h0B, 4'd0},
    '{2'd0, 1'b0, 24'h123456, 3'd0, 32'h0,        3'd0, 8'h03, 4'd2},
    '{2'd2, 1'b1, 24'h000001, 3'd7, 32'h11223344, 3'd0, 8'h02, 4'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [7:0]  cfg_cmd = '0;
  logic [2:0]  cfg_dummy = '0;
  logic [3:0]  cfg_div = 4'd2;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [23:0] addr = '0;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ready, sclk, cs_n, mosi, miso;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  spiflash_seq_top u_spiflash_seq_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_mode_i(cfg_mode), .cfg_cmd_i(cfg_cmd),
    .cfg_dummy_i(cfg_dummy), .cfg_div_i(cfg_div), .req_i(req), .we_i(we),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .ready_o(ready),
    .rdata_o(rdata), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // Flash model, SPI mode 0
  function automatic logic [7:0] resp(int k);
    return 8'hC3 ^ 8'(k * 29);
  endfunction

  logic [7:0] rec [16];
  int rec_n = 0;
  int bitc = 0;
  int cs_falls = 0;
  logic [7:0] shin = '0;
  logic [7:0] cur_tx;

  assign cur_tx = resp(rec_n);
  assign miso = cs_n ? 1'b0 : cur_tx[7 - bitc];

  always @(negedge cs_n) begin
    rec_n = 0;
    bitc = 0;
    cs_falls++;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      shin = {shin[6:0], mosi};
      if (bitc == 7) begin
        if (rec_n < 16) rec[rec_n] = shin;
        rec_n++;
        bitc = 0;
      end else bitc++;
    end
  end

  // Phase and gap length monitors
  int hi_run = 0, last_hi = 0;
  int gap_run = 0, last_gap = 0;
  always @(posedge clk) begin
    cyc++;
    if (sclk) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
    if (cs_n) gap_run++;
    else if (gap_run != 0) begin last_gap = gap_run; gap_run = 0; end
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  task automatic issue(input vec_t v, output logic [31:0] rd, output int wait_c);
    @(negedge clk);
    cfg_mode = v.mode; cfg_cmd = v.cmd; cfg_dummy = v.dummy; cfg_div = v.div;
    we = v.we; addr = v.addr; size = v.size; wdata = v.wdata; req = 1'b1;
    wait_c = 0;
    do begin
      @(negedge clk);
      wait_c++;
    end while (!ready && wait_c < 5000);
    rd = rdata;
    req = 1'b0;
    @(negedge clk);
    chk(!ready, "R10 single pulse", ready, 0);
  endtask

  initial begin
    logic [31:0] rd;
    int wc;
    int prev_hd;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R13 cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R13 sclk", sclk, 0);
    chk(mosi == 1'b0, "R13 mosi", mosi, 0);
    chk(ready == 1'b0, "R13 ready", ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    prev_hd = 0;
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int nd, sz, hd, tot;
      logic [23:0] ea;
      logic [31:0] exp_rd;
      v  = VECS[i];
      nd = (v.mode == 2'd1) ? int'(v.dummy) : 0;
      sz = (v.size == 0) ? 1 : ((v.size > 4) ? 4 : int'(v.size));
      hd = (v.div < 2) ? 2 : int'(v.div);
      ea = v.addr & 24'h0FFFFF;
      tot = 4 + nd + sz;
      issue(v, rd, wc);
      chk(cs_n == 1'b1, "R9 cs high after access", cs_n, 1);
      chk(rec_n == tot, "R4 R5 R12 byte count", rec_n, tot);
      chk(rec[0] == v.cmd, "R1 opcode", rec[0], v.cmd);
      chk({rec[1], rec[2], rec[3]} == ea, "R2 R3 address", {rec[1], rec[2], rec[3]}, ea);
      for (int d = 0; d < nd; d++)
        chk(rec[4 + d] == 8'hFF, "R4 filler", rec[4 + d], 8'hFF);
      exp_rd = '0;
      for (int j = 0; j < sz; j++) begin
        if (v.we) begin
          chk(rec[4 + nd + j] == v.wdata[8*j +: 8], "R7 write byte", rec[4 + nd + j], v.wdata[8*j +: 8]);
        end else begin
          chk(rec[4 + nd + j] == 8'h00, "R6 read filler out", rec[4 + nd + j], 0);
          exp_rd[8*j +: 8] = resp(4 + nd + j);
        end
      end
      if (!v.we) chk(rd == exp_rd, "R6 rdata packing", rd, exp_rd);
      chk(last_hi == hd, "R8 phase length", last_hi, hd);
      if (prev_hd != 0)
        chk(last_gap >= 2 * prev_hd, "R9 deselect gap", last_gap, 2 * prev_hd);
      prev_hd = hd;
    end

    // R11: mismatched or disabled requests leave the flash idle
    begin
      vec_t bad [3];
      int falls0;
      bad[0] = '{2'd0, 1'b1, 24'h000100, 3'd4, 32'hDEADBEEF, 3'd0, 8'h03, 4'd2};
      bad[1] = '{2'd2, 1'b0, 24'h000200, 3'd4, 32'h0,        3'd0, 8'h02, 4'd2};
      bad[2] = '{2'd3, 1'b0, 24'h000300, 3'd2, 32'h0,        3'd0, 8'h0B, 4'd2};
      for (int b = 0; b < 3; b++) begin
        falls0 = cs_falls;
        issue(bad[b], rd, wc);
        chk(cs_falls == falls0, "R11 no select", cs_falls - falls0, 0);
        chk(rd == 32'h0, "R11 zero data", rd, 0);
        chk(wc <= 3, "R11 fast completion", wc, 3);
      end
    end

    // R9: ready stays low through a long access
    begin
      vec_t v;
      int seen;
      v = '{2'd1, 1'b0, 24'h000010, 3'd4, 32'h0, 3'd2, 8'h0B, 4'd2};
      @(negedge clk);
      cfg_mode = v.mode; cfg_cmd = v.cmd; cfg_dummy = v.dummy; cfg_div = v.div;
      we = v.we; addr = v.addr; size = v.size; wdata = v.wdata; req = 1'b1;
      seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (ready) seen++;
      end
      chk(seen == 0 && !cs_n, "R9 back-pressure", seen, 0);
      wc = 0;
      while (!ready && wc < 5000) begin @(negedge clk); wc++; end
      req = 1'b0;
      chk(ready == 1'b1, "R10 completion seen", ready, 1);
      repeat (8) @(negedge clk);
    end

    finish_run();
  end
endmodule